// File: doc/BRIEF.md
# External Master Inbound Bridge

This block is the slave port through which a master sitting on the external bus reaches on-chip resources. Once the master owns the bus, it raises a one-cycle transfer-start strobe together with a 24-bit external address. The top bit of that address decides whether the access is for the chip at all. Off-chip accesses are left alone: the block forwards nothing and answers nothing.

For an on-chip access, the four upper external address bits form a region code. The block compresses this code into the upper twelve bits of a 32-bit internal address. The lower twenty bits pass through unchanged. One region, the flash window, also carries two of its code bits into the rebuilt address.

The block then raises a single internal request. It holds the request until the internal side returns ready or error, and it closes the external transfer with a one-cycle acknowledge or a one-cycle error acknowledge. An access to the reserved region is refused at once with the error acknowledge. Bit numbering in the text below is little-endian on the vectors: `ext_addr[23]` is the most significant external bit, and `int_addr[31:24]` is the top internal byte.

Top module: `xib_bridge`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `ext_ack`, `ext_err` and `int_req` are low.
- R2: A start strobe with `ext_addr[23]`=0 (off-chip) raises neither `int_req`, `ext_ack` nor `ext_err`.
- R3: Region code `ext_addr[23:22]`=2'b10 (flash) issues a request with `int_addr[31:24]`=8'h00 and `int_addr[23:20]`={2'b00, `ext_addr[21:20]`}.
- R4: Region code `ext_addr[23:20]`=4'b1100 (SRAM) issues a request with `int_addr[31:20]`=12'h400.
- R5: Region code 4'b1110 issues a request with `int_addr[31:20]`=12'hC3F, and region code 4'b1111 issues a request with `int_addr[31:20]`=12'hFFF. For every issued request, `int_addr[19:0]` equals `ext_addr[19:0]`.
- R6: Region code 4'b1101 (reserved) raises `ext_err` for exactly the one cycle after the strobe and never raises `int_req`.
- R7: An accepted on-chip strobe raises `int_req` in the next cycle. `int_req`, `int_addr`, `int_write` and `int_wdata` then hold until a cycle in which `int_ready` or `int_error` is high.
- R8: `int_ready` with `int_error` low ends the request and raises `ext_ack` for exactly one cycle, in the next cycle. In that cycle `ext_rdata` equals the `int_rdata` returned with the ready.
- R9: `int_error` high while the request is held raises `ext_err` for exactly one cycle instead of `ext_ack`. This holds even when `int_ready` is high in the same cycle.
- R10: `ext_ack` and `ext_err` are never high together.
- R11: A start strobe that arrives while an access is in flight, or during its acknowledge cycle, is ignored. It does not change `int_addr`, and it starts no second request.
- R12: `int_write` and `int_wdata` equal the `ext_write` and `ext_wdata` sampled with the accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_start | input | 1 | Transfer-start strobe from the external master |
| ext_addr | input | 24 | External address; bit 23 selects on-chip space |
| ext_write | input | 1 | External access direction, 1 = write |
| ext_wdata | input | 32 | External write data |
| ext_ack | output | 1 | One-cycle successful-termination acknowledge |
| ext_err | output | 1 | One-cycle error acknowledge |
| ext_rdata | output | 32 | Read data captured on completion |
| int_req | output | 1 | Internal request, held until answered |
| int_addr | output | 32 | Rebuilt internal address |
| int_write | output | 1 | Internal access direction |
| int_wdata | output | 32 | Internal write data |
| int_ready | input | 1 | Internal completion |
| int_error | input | 1 | Internal address or data fault |
| int_rdata | input | 32 | Internal read data |

## Verification
A wrong region decode shows on `int_addr` in the first cycle after the strobe. A lost or stuck sequencer state shows within a cycle or two as a missing request, a request that never drops, a second acknowledge cycle or a doubled response. The bench sweeps all sixteen region codes against three low-address, direction and response patterns. It samples each cycle of an access, so a fault in the remap, the hold, the response selection or the busy-time filtering of strobes shows up in the same access that triggers it.

// File: rtl/xib_pkg.sv
package xib_pkg;

    localparam int EXT_AW   = 24;
    localparam int INT_AW   = 32;
    localparam int DATA_W   = 32;
    localparam int CODE_W   = 4;
    localparam int HI_W     = 8;
    localparam int MID_W    = 4;
    localparam int PASS_W   = EXT_AW - CODE_W;   // bits copied straight through
    localparam int CODE_LSB = EXT_AW - CODE_W;

    typedef enum logic [2:0] {
        RG_OFFCHIP,
        RG_FLASH,
        RG_SRAM,
        RG_RESERVED,
        RG_PERIPH_A,
        RG_PERIPH_B
    } region_e;

    typedef struct packed {
        region_e            region;
        logic [HI_W-1:0]    hi;
        logic [MID_W-1:0]   mid;
    } remap_t;

    typedef struct packed {
        logic [INT_AW-1:0]  addr;
        logic               write;
        logic [DATA_W-1:0]  wdata;
    } xfer_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_BUSY,
        SEQ_RESP
    } seq_e;

    // Compress a region code into the upper internal address fields.
    function automatic remap_t decode_region(input logic [CODE_W-1:0] code);
        remap_t r;
        r.region = RG_OFFCHIP;
        r.hi     = '0;
        r.mid    = '0;
        if (code[3]) begin
            if (!code[2]) begin
                r.region = RG_FLASH;
                r.hi     = 8'h00;
                r.mid    = {2'b00, code[1:0]};
            end else begin
                case (code[1:0])
                    2'b00: begin r.region = RG_SRAM;     r.hi = 8'h40; r.mid = 4'h0; end
                    2'b01: begin r.region = RG_RESERVED; r.hi = 8'h60; r.mid = 4'h0; end
                    2'b10: begin r.region = RG_PERIPH_A; r.hi = 8'hC3; r.mid = 4'hF; end
                    default: begin r.region = RG_PERIPH_B; r.hi = 8'hFF; r.mid = 4'hF; end
                endcase
            end
        end
        return r;
    endfunction

    function automatic logic is_forwarded(input region_e rg);
        return (rg != RG_OFFCHIP) && (rg != RG_RESERVED);
    endfunction

endpackage

// File: rtl/xib_region_decode.sv
module xib_region_decode
    import xib_pkg::*;
#(
    parameter int EAW = xib_pkg::EXT_AW,
    parameter int IAW = xib_pkg::INT_AW
) (
    input  logic [EAW-1:0] ext_addr_i,
    output region_e        region_o,
    output logic [IAW-1:0] int_addr_o
);
    localparam int PW = EAW - CODE_W;

    remap_t info;

    always_comb begin
        info       = decode_region(ext_addr_i[EAW-1 -: CODE_W]);
        region_o   = info.region;
        int_addr_o = {info.hi, info.mid, ext_addr_i[PW-1:0]};
    end
endmodule

// File: rtl/xib_txn_ctrl.sv
module xib_txn_ctrl
    import xib_pkg::*;
#(
    parameter int IAW = xib_pkg::INT_AW,
    parameter int DW  = xib_pkg::DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  region_e        region_i,
    input  logic [IAW-1:0] mapped_addr_i,
    input  logic           write_i,
    input  logic [DW-1:0]  wdata_i,
    output logic           ack_o,
    output logic           err_o,
    output logic [DW-1:0]  rdata_o,
    output logic           req_o,
    output logic [IAW-1:0] addr_o,
    output logic           write_o,
    output logic [DW-1:0]  wdata_o,
    input  logic           ready_i,
    input  logic           error_i,
    input  logic [DW-1:0]  rdata_i
);
    seq_e  state;
    xfer_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            req_o   <= 1'b0;
            ack_o   <= 1'b0;
            err_o   <= 1'b0;
            rdata_o <= '0;
            held    <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    ack_o <= 1'b0;
                    err_o <= 1'b0;
                    if (start_i && region_i != RG_OFFCHIP) begin
                        if (is_forwarded(region_i)) begin
                            req_o       <= 1'b1;
                            held.addr   <= mapped_addr_i;
                            held.write  <= write_i;
                            held.wdata  <= wdata_i;
                            state       <= SEQ_BUSY;
                        end else begin
                            err_o <= 1'b1;
                            state <= SEQ_RESP;
                        end
                    end
                end
                SEQ_BUSY: begin
                    if (error_i) begin
                        req_o <= 1'b0;
                        err_o <= 1'b1;
                        state <= SEQ_RESP;
                    end else if (ready_i) begin
                        req_o   <= 1'b0;
                        ack_o   <= 1'b1;
                        rdata_o <= rdata_i;
                        state   <= SEQ_RESP;
                    end
                end
                default: begin
                    ack_o <= 1'b0;
                    err_o <= 1'b0;
                    state <= SEQ_IDLE;
                end
            endcase
        end
    end

    assign addr_o  = held.addr;
    assign write_o = held.write;
    assign wdata_o = held.wdata;
endmodule

// File: rtl/xib_bridge.sv
module xib_bridge
    import xib_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_start,
    input  logic [EXT_AW-1:0] ext_addr,
    input  logic              ext_write,
    input  logic [DATA_W-1:0] ext_wdata,
    output logic              ext_ack,
    output logic              ext_err,
    output logic [DATA_W-1:0] ext_rdata,
    output logic              int_req,
    output logic [INT_AW-1:0] int_addr,
    output logic              int_write,
    output logic [DATA_W-1:0] int_wdata,
    input  logic              int_ready,
    input  logic              int_error,
    input  logic [DATA_W-1:0] int_rdata
);
    region_e           region;
    logic [INT_AW-1:0] mapped_addr;

    xib_region_decode #(.EAW(EXT_AW), .IAW(INT_AW)) u_decode (
        .ext_addr_i (ext_addr),
        .region_o   (region),
        .int_addr_o (mapped_addr)
    );

    xib_txn_ctrl #(.IAW(INT_AW), .DW(DATA_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .start_i       (ext_start),
        .region_i      (region),
        .mapped_addr_i (mapped_addr),
        .write_i       (ext_write),
        .wdata_i       (ext_wdata),
        .ack_o         (ext_ack),
        .err_o         (ext_err),
        .rdata_o       (ext_rdata),
        .req_o         (int_req),
        .addr_o        (int_addr),
        .write_o       (int_write),
        .wdata_o       (int_wdata),
        .ready_i       (int_ready),
        .error_i       (int_error),
        .rdata_i       (int_rdata)
    );
endmodule

// File: rtl/xib_bridge_chk.sv
module xib_bridge_chk
    import xib_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ext_start,
    input logic [EXT_AW-1:0] ext_addr,
    input logic              ext_ack,
    input logic              ext_err,
    input logic              int_req,
    input logic [INT_AW-1:0] int_addr,
    input logic              int_ready,
    input logic              int_error
);
    logic idle;
    assign idle = !int_req && !ext_ack && !ext_err;

    assert_offchip_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (idle && ext_start && !ext_addr[EXT_AW-1]) |=> idle);

    assert_flash_remap_R3: assert property (@(posedge clk) disable iff (rst)
        (idle && ext_start && ext_addr[EXT_AW-1 -: 2] == 2'b10) |=>
        (int_req && int_addr[31:20] == {10'b0, $past(ext_addr[21:20])}
                 && int_addr[19:0] == $past(ext_addr[19:0])));

    assert_reserved_refused_R6: assert property (@(posedge clk) disable iff (rst)
        (idle && ext_start && ext_addr[EXT_AW-1 -: 4] == 4'hD) |=> (ext_err && !int_req));

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (int_req && !int_ready && !int_error) |=> (int_req && $stable(int_addr)));

    assert_ready_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (int_req && int_ready && !int_error) |=> (ext_ack && !int_req));

    assert_error_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (int_req && int_error) |=> (ext_err && !ext_ack && !int_req));

    assert_err_single_R9: assert property (@(posedge clk) disable iff (rst)
        ext_err |=> !ext_err);

    assert_ack_single_R10: assert property (@(posedge clk) disable iff (rst)
        ext_ack |=> !ext_ack);

    assert_ack_err_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(ext_ack && ext_err));
endmodule

bind xib_bridge xib_bridge_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ext_start (ext_start),
    .ext_addr  (ext_addr),
    .ext_ack   (ext_ack),
    .ext_err   (ext_err),
    .int_req   (int_req),
    .int_addr  (int_addr),
    .int_ready (int_ready),
    .int_error (int_error)
);

// File: tb/xib_bridge_tb.sv
module xib_bridge_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        ext_start;
    logic [23:0] ext_addr;
    logic        ext_write;
    logic [31:0] ext_wdata;
    logic        ext_ack;
    logic        ext_err;
    logic [31:0] ext_rdata;
    logic        int_req;
    logic [31:0] int_addr;
    logic        int_write;
    logic [31:0] int_wdata;
    logic        int_ready;
    logic        int_error;
    logic [31:0] int_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xib_bridge u_dut (
        .clk(clk), .rst(rst), .ext_start(ext_start), .ext_addr(ext_addr),
        .ext_write(ext_write), .ext_wdata(ext_wdata), .ext_ack(ext_ack),
        .ext_err(ext_err), .ext_rdata(ext_rdata), .int_req(int_req),
        .int_addr(int_addr), .int_write(int_write), .int_wdata(int_wdata),
        .int_ready(int_ready), .int_error(int_error), .int_rdata(int_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected upper twelve internal address bits per region code (R3, R4, R5).
    function automatic logic [11:0] exp_upper(input logic [3:0] code);
        if (code[3:2] == 2'b10) return {8'h00, 2'b00, code[1:0]};
        case (code)
            4'hC:    return 12'h400;
            4'hE:    return 12'hC3F;
            default: return 12'hFFF;
        endcase
    endfunction

    // kind: 0 = ready, 1 = error, 2 = ready and error together
    task automatic access(input logic [3:0] code, input logic [19:0] low, input logic wr,
                          input logic [31:0] wd, input int kind, input int delay,
                          input logic [31:0] rd);
        logic [23:0] a;
        logic [31:0] ea;
        string tag;
        a  = {code, low};
        ea = {exp_upper(code), low};
        tag = (code[3:2] == 2'b10) ? "R3" : (code == 4'hC) ? "R4" : "R5";
        @(negedge clk);
        ext_start = 1'b1; ext_addr = a; ext_write = wr; ext_wdata = wd;
        @(negedge clk);
        ext_start = 1'b0;
        if (!code[3]) begin
            check("R2 int_req", {31'b0, int_req}, 32'd0);
            check("R2 ack/err", {30'b0, ext_ack, ext_err}, 32'd0);
            @(negedge clk);
            check("R2 later", {29'b0, int_req, ext_ack, ext_err}, 32'd0);
            return;
        end
        if (code == 4'hD) begin
            check("R6 err", {31'b0, ext_err}, 32'd1);
            check("R6 no req", {30'b0, int_req, ext_ack}, 32'd0);
            @(negedge clk);
            check("R6 single", {29'b0, ext_err, int_req, ext_ack}, 32'd0);
            return;
        end
        check("R7 req", {31'b0, int_req}, 32'd1);
        check(tag, int_addr, ea);
        check("R12 write", {31'b0, int_write}, {31'b0, wr});
        check("R12 wdata", int_wdata, wd);
        for (int i = 0; i < delay; i++) begin
            ext_start = 1'b1; ext_addr = ~a;   // strobe while busy: R11
            @(negedge clk);
            ext_start = 1'b0;
            check("R7 hold req", {31'b0, int_req}, 32'd1);
            check("R11 addr kept", int_addr, ea);
            check("R12 wdata kept", int_wdata, wd);
        end
        int_ready = (kind != 1); int_error = (kind != 0); int_rdata = rd;
        ext_start = 1'b1; ext_addr = ~a;       // strobe on completion edge: R11
        @(negedge clk);
        int_ready = 1'b0; int_error = 1'b0; ext_start = 1'b0;
        check("R7 req drop", {31'b0, int_req}, 32'd0);
        if (kind == 0) begin
            check("R8 ack", {30'b0, ext_ack, ext_err}, 32'd2);
            check("R8 rdata", ext_rdata, rd);
        end else begin
            check("R9 err", {30'b0, ext_ack, ext_err}, 32'd1);
        end
        @(negedge clk);
        check("R10 single", {30'b0, ext_ack, ext_err}, 32'd0);
        check("R11 no 2nd req", {31'b0, int_req}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; ext_start = 1'b0; ext_addr = '0; ext_write = 1'b0; ext_wdata = '0;
        int_ready = 1'b0; int_error = 1'b0; int_rdata = '0;
        repeat (3) @(negedge clk);
        check("R1 in reset", {29'b0, ext_ack, ext_err, int_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {29'b0, ext_ack, ext_err, int_req}, 32'd0);
        for (int code = 0; code < 16; code++) begin
            for (int pat = 0; pat < 3; pat++) begin
                logic [19:0] low;
                logic [31:0] wd, rd;
                low = 20'(pat * 32'h3A5C1 ^ code * 32'h1111 ^ (pat == 2 ? 32'hFFFFF : 0));
                wd  = 32'hA5000000 + 32'(code * 256 + pat);
                rd  = 32'h5A000000 ^ 32'(code * 4099 + pat * 77);
                access(4'(code), low, pat[0], wd, (code + pat) % 3, pat, rd);
            end
        end
        // Back-to-back strobe right after an acknowledge is accepted normally.
        access(4'hC, 20'h00001, 1'b1, 32'h1234_5678, 0, 0, 32'hCAFE_0001);
        access(4'hF, 20'hFFFFF, 1'b0, 32'h0, 2, 1, 32'hCAFE_0002);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule